// File: doc/BRIEF.md
# Flash Lockout Recovery Controller

This block gets a flash array back into use after its security setting has locked out debug reads. A simplified test-port front end drives it. An instruction-update strobe carries an opcode. A serial data register of DIV_W+1 bits fills while a shift strobe is held. A data-update strobe then commits that register. When the recovery opcode is the current instruction, the committed register value replaces the normal flash timing-divider setting. The value feeds a two-stage divider that produces the timed-event clock enable.

Recovery follows a named sequence. From `IDLE`, selecting the recovery instruction moves the sequencer to `WAIT_CLKCFG`. Deselecting it there goes back to `IDLE`. A data-register update in `WAIT_CLKCFG` commits the divider value and moves to `ERASE`. In `ERASE` the mass-erase request to the flash array is held high. The erase-done reply moves the sequencer to `DONE`. `DONE` is left only by reset. The divider value is frozen from the start of `ERASE` onward.

The debug-read block output comes from the stored security bytes, which are sampled on the first clock after reset. A sticky erase-complete flag survives the system reset and is cleared only by power-on reset. If that flag is set when the security value is sampled, the block comes up unsecured and the flag is cleared. Security is therefore never released in the middle of an erase. It is released only on the reset that follows a completed erase.

Top module: `flash_recovery_ctrl`

## Requirements
- R1: After power-on reset, erase_req, erase_complete and recov_mode are 0, and tm_tick follows norm_clkdiv.
- R2: On an ir_upd strobe, recov_mode becomes 1 on the next clock if ir_code equals RECOV_OP (default 4'hB) and 0 for any other code. It holds between strobes.
- R3: The divider takes the committed test-port value while recov_mode is 1 or an erase is in progress or finished. Otherwise it takes norm_clkdiv.
- R4: Bit 6 of the divider value selects a divide-by-8 prescaler and bits 5:0 give N. tm_tick pulses once every (bit6 ? 8 : 1) * (N + 1) clocks. The bit shifted in first while dr_shift is high lands in bit 0.
- R5: A dr_upd strobe in WAIT_CLKCFG (recovery selected) raises erase_req on the clock that samples the strobe.
- R6: erase_req stays high until erase_done is sampled. On that clock erase_req falls and erase_complete rises, and the two are never high together.
- R7: A dr_upd strobe during or after an erase leaves the divider, and so the tm_tick period, unchanged.
- R8: On the first clock after a reset, dbg_rd_block loads the value of sec_bytes_locked when no erase has completed since power-on.
- R9: dbg_rd_block stays unchanged through the erase and in DONE. On the first clock after the next system reset it loads 0 whatever sec_bytes_locked says.
- R10: The load in R9 clears erase_complete, so a further reset samples sec_bytes_locked again.
- R11: Deselecting the recovery instruction in WAIT_CLKCFG returns to IDLE, where a dr_upd strobe starts no erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (flash module input clock) |
| por_n | input | 1 | Power-on reset, active low; also clears the erase-complete flag |
| rst_n | input | 1 | System reset, active low; keeps the erase-complete flag |
| ir_upd | input | 1 | Instruction-update strobe |
| ir_code | input | IR_W | Opcode presented with ir_upd |
| dr_shift | input | 1 | Shift enable for the divider data register |
| dr_tdi | input | 1 | Serial data in, least significant bit first |
| dr_upd | input | 1 | Data-register update strobe |
| norm_clkdiv | input | DIV_W+1 | Normal divider setting {prescale select, N} |
| sec_bytes_locked | input | 1 | Stored security bytes say secured |
| erase_done | input | 1 | Mass erase finished, from the flash array |
| tm_tick | output | 1 | Timed-event clock enable |
| erase_req | output | 1 | Mass-erase request to the flash array |
| erase_complete | output | 1 | Sticky flag, set once a full erase is done |
| recov_mode | output | 1 | Recovery instruction is selected |
| dbg_rd_block | output | 1 | Blocks debug reads of internal memory |

## Verification
Every stimulus is driven on the falling edge and every result is sampled on a later falling edge. recov_mode, erase_req, and the end of erase_req with erase_complete are all due exactly one rising edge after their strobe, so each is read on the next falling edge. dbg_rd_block settles on the first rising edge after reset release, and erase_complete clears on that same edge, so both are read two falling edges later. After any divider change the bench waits three clocks for the counters to restart. It then waits for a tick and counts the clocks to the next tick. That count is compared with a bench function of the value that should be in force, covering random normal settings, a random recovery value, and a rejected second update.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        S_IDLE        = 2'd0,
        S_WAIT_CLKCFG = 2'd1,
        S_ERASE       = 2'd2,
        S_DONE        = 2'd3
    } frc_state_e;

    // tick period in clocks for a {prescale_sel, N} setting
    function automatic int unsigned frc_period(input logic pre_sel,
                                               input int unsigned n,
                                               input int unsigned ratio);
        return (pre_sel ? ratio : 1) * (n + 1);
    endfunction

endpackage

// File: rtl/frc_tap_regs.sv
module frc_tap_regs #(
    parameter int unsigned IR_W     = 4,
    parameter int unsigned DR_W     = 7,
    parameter logic [IR_W-1:0] RECOV_OP = 4'hB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ir_upd,
    input  logic [IR_W-1:0] ir_code,
    input  logic            dr_shift,
    input  logic            dr_tdi,
    input  logic            upd_accept,
    output logic            recov_mode,
    output logic [DR_W-1:0] jtag_cfg
);

    logic [DR_W-1:0] shift_q;
    logic            recov_q;

    // instruction decode: the selected opcode is held between strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recov_q <= 1'b0;
        end else if (ir_upd) begin
            recov_q <= (ir_code == RECOV_OP);
        end
    end

    // serial capture, least significant bit first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (dr_shift && recov_q) begin
            shift_q <= {dr_tdi, shift_q[DR_W-1:1]};
        end
    end

    // committed divider value, written only when the sequencer allows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jtag_cfg <= '0;
        end else if (upd_accept) begin
            jtag_cfg <= shift_q;
        end
    end

    assign recov_mode = recov_q;

endmodule

// File: rtl/frc_clk_div.sv
module frc_clk_div #(
    parameter int unsigned DIV_W     = 6,
    parameter int unsigned PRE_RATIO = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIV_W:0] cfg,
    output logic           tick
);

    localparam int unsigned PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_RATIO - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] main_q;
    logic [DIV_W:0]   cfg_q;
    logic             pre_sel;
    logic [DIV_W-1:0] div_n;
    logic             restart;
    logic             pre_carry;
    logic             main_wrap;

    assign pre_sel   = cfg[DIV_W];
    assign div_n     = cfg[DIV_W-1:0];
    assign restart   = (cfg != cfg_q);
    assign pre_carry = !pre_sel || (pre_q == PRE_MAX);
    assign main_wrap = (main_q == div_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pre_q  <= '0;
            main_q <= '0;
        end else begin
            cfg_q <= cfg;
            if (restart) begin
                pre_q  <= '0;
                main_q <= '0;
            end else if (pre_carry) begin
                pre_q  <= '0;
                main_q <= main_wrap ? '0 : main_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign tick = pre_carry && main_wrap && !restart;

endmodule

// File: rtl/frc_erase_fsm.sv
module frc_erase_fsm
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic recov_mode,
    input  logic upd_req,
    input  logic erase_done,
    input  logic sec_bytes_locked,
    output logic upd_accept,
    output logic locked,
    output logic erase_req,
    output logic erase_complete,
    output logic dbg_rd_block
);

    frc_state_e state_q, state_d;
    logic       sticky_q;
    logic       sec_q;
    logic       load_pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (recov_mode) state_d = S_WAIT_CLKCFG;
            S_WAIT_CLKCFG: begin
                if (upd_req)          state_d = S_ERASE;
                else if (!recov_mode) state_d = S_IDLE;
            end
            S_ERASE:       if (erase_done) state_d = S_DONE;
            S_DONE:        state_d = S_DONE;
            default:       state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        erase_req  = 1'b0;
        locked     = 1'b0;
        upd_accept = 1'b0;
        unique case (state_q)
            S_IDLE:        upd_accept = upd_req;
            S_WAIT_CLKCFG: upd_accept = upd_req;
            S_ERASE: begin
                erase_req = 1'b1;
                locked    = 1'b1;
            end
            S_DONE:        locked = 1'b1;
            default: ;
        endcase
    end

    // erase-complete flag kept through system reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sticky_q <= 1'b0;
        end else if (rst_n && load_pend_q) begin
            sticky_q <= 1'b0;
        end else if (state_q == S_ERASE && erase_done) begin
            sticky_q <= 1'b1;
        end
    end

    // security sampled once, on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q       <= 1'b1;
            load_pend_q <= 1'b1;
        end else if (load_pend_q) begin
            sec_q       <= sticky_q ? 1'b0 : sec_bytes_locked;
            load_pend_q <= 1'b0;
        end
    end

    assign erase_complete = sticky_q;
    assign dbg_rd_block   = sec_q;

endmodule

// File: rtl/flash_recovery_ctrl.sv
module flash_recovery_ctrl #(
    parameter int unsigned IR_W      = 4,
    parameter int unsigned DIV_W     = 6,
    parameter int unsigned PRE_RATIO = 8,
    parameter logic [IR_W-1:0] RECOV_OP = 4'hB
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             ir_upd,
    input  logic [IR_W-1:0]  ir_code,
    input  logic             dr_shift,
    input  logic             dr_tdi,
    input  logic             dr_upd,
    input  logic [DIV_W:0]   norm_clkdiv,
    input  logic             sec_bytes_locked,
    input  logic             erase_done,
    output logic             tm_tick,
    output logic             erase_req,
    output logic             erase_complete,
    output logic             recov_mode,
    output logic             dbg_rd_block
);

    localparam int unsigned DR_W = DIV_W + 1;

    logic            sys_rst_n;
    logic            upd_accept;
    logic            locked;
    logic [DR_W-1:0] jtag_cfg;
    logic [DR_W-1:0] eff_cfg;

    assign sys_rst_n = rst_n & por_n;

    frc_tap_regs #(
        .IR_W     (IR_W),
        .DR_W     (DR_W),
        .RECOV_OP (RECOV_OP)
    ) u_tap (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .ir_upd     (ir_upd),
        .ir_code    (ir_code),
        .dr_shift   (dr_shift),
        .dr_tdi     (dr_tdi),
        .upd_accept (upd_accept),
        .recov_mode (recov_mode),
        .jtag_cfg   (jtag_cfg)
    );

    frc_erase_fsm u_fsm (
        .clk              (clk),
        .rst_n            (sys_rst_n),
        .por_n            (por_n),
        .recov_mode       (recov_mode),
        .upd_req          (dr_upd & recov_mode),
        .erase_done       (erase_done),
        .sec_bytes_locked (sec_bytes_locked),
        .upd_accept       (upd_accept),
        .locked           (locked),
        .erase_req        (erase_req),
        .erase_complete   (erase_complete),
        .dbg_rd_block     (dbg_rd_block)
    );

    // test-port value wins while recovery is selected or the erase owns it
    assign eff_cfg = (recov_mode || locked) ? jtag_cfg : norm_clkdiv;

    frc_clk_div #(
        .DIV_W     (DIV_W),
        .PRE_RATIO (PRE_RATIO)
    ) u_div (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .cfg   (eff_cfg),
        .tick  (tm_tick)
    );

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int unsigned DR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dr_upd,
    input logic            erase_req,
    input logic            erase_done,
    input logic            erase_complete,
    input logic            dbg_rd_block,
    input logic [DR_W-1:0] eff_cfg
);

    logic ld_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_seen_q <= 1'b0;
        else        ld_seen_q <= 1'b1;
    end

    AST_REQ_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> $past(dr_upd)); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> erase_req); // R6

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_complete |-> !erase_req); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && $past(erase_req)) |-> $stable(eff_cfg)); // R7

    AST_SEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_seen_q |=> $stable(dbg_rd_block)); // R9

endmodule

bind flash_recovery_ctrl frc_checker #(.DR_W(DR_W)) u_chk (
    .clk            (clk),
    .rst_n          (sys_rst_n),
    .dr_upd         (dr_upd),
    .erase_req      (erase_req),
    .erase_done     (erase_done),
    .erase_complete (erase_complete),
    .dbg_rd_block   (dbg_rd_block),
    .eff_cfg        (eff_cfg)
);

// File: tb/test_flash_recovery_ctrl.sv
`timescale 1ns/1ps
module test_flash_recovery_ctrl;

    localparam int unsigned IR_W  = 4;
    localparam int unsigned DIV_W = 6;
    localparam logic [IR_W-1:0] OP_RECOV = 4'hB;
    localparam logic [IR_W-1:0] OP_OTHER = 4'h3;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             rst_n = 1'b0;
    logic             ir_upd = 1'b0;
    logic [IR_W-1:0]  ir_code = '0;
    logic             dr_shift = 1'b0;
    logic             dr_tdi = 1'b0;
    logic             dr_upd = 1'b0;
    logic [DIV_W:0]   norm_clkdiv = 7'h01;
    logic             sec_bytes_locked = 1'b1;
    logic             erase_done = 1'b0;
    logic             tm_tick, erase_req, erase_complete, recov_mode, dbg_rd_block;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_recovery_ctrl i_flash_recovery_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ir_upd(ir_upd), .ir_code(ir_code),
        .dr_shift(dr_shift), .dr_tdi(dr_tdi), .dr_upd(dr_upd), .norm_clkdiv(norm_clkdiv),
        .sec_bytes_locked(sec_bytes_locked), .erase_done(erase_done), .tm_tick(tm_tick),
        .erase_req(erase_req), .erase_complete(erase_complete), .recov_mode(recov_mode),
        .dbg_rd_block(dbg_rd_block)
    );

    function automatic int exp_period(input logic [DIV_W:0] v);
        return (v[DIV_W] ? 8 : 1) * (int'(v[DIV_W-1:0]) + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int p);
        int n;
        p = -1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (tm_tick) break;
        end
        n = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            n++;
            if (tm_tick) begin
                p = n;
                break;
            end
        end
    endtask

    task automatic ir_load(input logic [IR_W-1:0] code);
        @(negedge clk);
        ir_upd = 1'b1; ir_code = code;
        @(negedge clk);
        ir_upd = 1'b0;
    endtask

    task automatic dr_shift_in(input logic [DIV_W:0] v);
        for (int i = 0; i <= DIV_W; i++) begin
            @(negedge clk);
            dr_shift = 1'b1; dr_tdi = v[i];
        end
        @(negedge clk);
        dr_shift = 1'b0;
    endtask

    task automatic pulse_upd();
        dr_upd = 1'b1;
        @(negedge clk);
        dr_upd = 1'b0;
    endtask

    task automatic sys_reset(input bit power_on);
        @(negedge clk);
        rst_n = 1'b0;
        if (power_on) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #800us;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p;
        logic [DIV_W:0] v, jv, jv2;
        void'($urandom(32'd7051));

        sys_reset(1'b1);
        chk("R1 erase_req", int'(erase_req), 0);
        chk("R1 erase_complete", int'(erase_complete), 0);
        chk("R1 recov_mode", int'(recov_mode), 0);
        chk("R8 dbg_rd_block secured bytes", int'(dbg_rd_block), 1);

        // random normal settings: R1 R3 R4
        for (int k = 0; k < 6; k++) begin
            v = {1'($urandom_range(0, 1)), 6'($urandom_range(0, 15))};
            @(negedge clk);
            norm_clkdiv = v;
            measure(p);
            chk("R4 normal period", p, exp_period(v));
        end
        // directed corners
        norm_clkdiv = 7'h00; measure(p); chk("R4 period min", p, 1);
        norm_clkdiv = 7'h45; measure(p); chk("R4 period prescaled", p, 48);

        // R2 instruction decode
        ir_load(OP_OTHER);
        chk("R2 other opcode", int'(recov_mode), 0);
        ir_load(OP_RECOV);
        chk("R2 recovery opcode", int'(recov_mode), 1);

        // R11 deselect in WAIT_CLKCFG then update
        repeat (2) @(negedge clk);
        ir_load(OP_OTHER);
        chk("R2 deselect", int'(recov_mode), 0);
        @(negedge clk);
        pulse_upd();
        chk("R11 no erase from IDLE", int'(erase_req), 0);
        norm_clkdiv = 7'h02;
        measure(p);
        chk("R11 divider stays normal", p, 3);

        // main recovery pass
        jv = {1'b1, 6'($urandom_range(1, 7))};
        norm_clkdiv = 7'h04;
        ir_load(OP_RECOV);
        dr_shift_in(jv);
        chk("R5 no request before update", int'(erase_req), 0);
        pulse_upd();
        chk("R5 erase_req after update", int'(erase_req), 1);
        measure(p);
        chk("R3 R4 recovery divider", p, exp_period(jv));

        // R7 later update ignored
        jv2 = {1'b0, ~jv[DIV_W-1:0]};
        dr_shift_in(jv2);
        pulse_upd();
        measure(p);
        chk("R7 divider frozen", p, exp_period(jv));
        chk("R6 request held", int'(erase_req), 1);
        chk("R9 blocked during erase", int'(dbg_rd_block), 1);

        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        chk("R6 request dropped", int'(erase_req), 0);
        chk("R6 erase_complete set", int'(erase_complete), 1);
        chk("R9 still blocked in DONE", int'(dbg_rd_block), 1);
        dr_shift_in(7'h00);
        pulse_upd();
        measure(p);
        chk("R7 divider frozen in DONE", p, exp_period(jv));

        // R9 R10 reset after erase
        sys_reset(1'b0);
        chk("R9 unsecured after reset", int'(dbg_rd_block), 0);
        chk("R10 flag cleared", int'(erase_complete), 0);
        chk("R1 recov cleared", int'(recov_mode), 0);
        sys_reset(1'b0);
        chk("R10 bytes sampled again", int'(dbg_rd_block), 1);

        // R8 unsecured bytes
        sec_bytes_locked = 1'b0;
        sys_reset(1'b1);
        chk("R8 unsecured bytes", int'(dbg_rd_block), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule